// File: doc/BRIEF.md
# 32-bit Shift and Normalize Unit

This unit takes a 32-bit word and moves it a programmed number of bit positions, one position per clock. The move can go left or right. Vacated positions are filled with zeros. If circular operation is selected, the bits that leave one end come back in at the other. A separate carry flag can be placed in the path. With carry included and no circular operation, every bit that leaves the word lands in the carry and the previous carry is dropped. With carry and circular operation together, the word and the carry rotate as a single 33-bit ring.

A programmed count of zero selects normalize. The word is moved left, with zero fill, until its top bit is 1. The number of positions moved is then reported on the count output. A word that is entirely zero stops after 31 positions and reports 31.

A client pulses `start` together with the operands. It watches `busy` and collects the result on the single-cycle `done` pulse. The outputs then hold until the next accepted start.

Top module: `shift_norm_unit`

## Requirements
- R1: With `shiftRight`=0, `circular`=0 and `withCarry`=0, a count k in 1..31 gives `dataOut` = `dataIn` shifted left by k with zeros entering at bit 0. `carryOut` equals the `carryIn` that was loaded.
- R2: With `shiftRight`=1, `circular`=0 and `withCarry`=0, a count k gives `dataIn` shifted right by k with zeros entering at bit 31. `carryOut` equals the loaded `carryIn`.
- R3: With `circular`=1 and `withCarry`=0, a count k rotates the 32-bit word by k positions in the selected direction. `carryOut` equals the loaded `carryIn`.
- R4: With `withCarry`=1 and `circular`=0, each step moves the bit leaving the word (bit 31 going left, bit 0 going right) into the carry, and a zero enters the word. The earlier carry is lost.
- R5: With `withCarry`=1 and `circular`=1, the carry and the word rotate together as a 33-bit ring. Going left, the carry enters at bit 0 and bit 31 becomes the carry. Going right, the carry enters at bit 31 and bit 0 becomes the carry.
- R6: A count of 0 selects normalize. The word is shifted left with zero fill until bit 31 is 1. `countOut` reports the number of positions moved, and `carryOut` keeps the loaded carry. `shiftRight`, `circular` and `withCarry` have no effect in this mode.
- R7: Normalizing an all-zero word returns `dataOut`=0 and `countOut`=31. `carryOut` keeps the loaded carry.
- R8: A start accepted at clock edge 0 raises `busy` from that edge on. For a shift of count k, `done` is high for exactly one cycle after edge k+1, and `busy` falls at that same edge. For a normalize that moves n positions, the same holds with n in place of k. While idle with no start, the outputs hold.
- R9: A `start` that arrives while `busy` is high is ignored. The running operation finishes with its original operands and timing.
- R10: After reset, `busy`, `done`, `dataOut`, `carryOut` and `countOut` are all 0.
- R11: In shift mode, `countOut` reports the programmed count during and after the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load the operands and begin, accepted only while idle |
| dataIn | input | 32 | Word to operate on |
| countIn | input | 5 | Number of positions; 0 selects normalize |
| shiftRight | input | 1 | 0 = left, 1 = right |
| circular | input | 1 | 1 = bits leaving one end re-enter at the other |
| withCarry | input | 1 | 1 = carry flag is part of the shift path |
| carryIn | input | 1 | Initial carry flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| dataOut | output | 32 | Shifted or normalized word |
| carryOut | output | 1 | Carry flag after the operation |
| countOut | output | 5 | Programmed count (shift) or positions moved (normalize) |

## Verification
The hardest situations to reach from the ports are the two ends of normalize. One is a word whose top bit is already set, which must finish after a single busy cycle with a count of 0. The other is the all-zero word, which must stop at the 31-position limit and not run on. Both are driven directly, along with a word whose only set bit is bit 0.

Start pulses are also injected during a running shift and a running normalize, with different operands on the inputs. Because the reference model computes the result and the latency from the original operands only, any reload or timing change appears as a mismatch on a later cycle.

// File: rtl/shift_norm_pkg.sv
package shift_norm_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture operands
    logic step;      // move one position
    logic normStep;  // step is a normalize step (left, zero fill, carry kept)
  } strobe_t;

  // Path configuration captured at load
  typedef struct packed {
    logic right;
    logic circ;
    logic withCarry;
  } shiftCfg_t;

endpackage

// File: rtl/shift_norm_ctrl.sv
module shift_norm_ctrl
  import shift_norm_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] countIn,
  input  logic             msb,
  output strobe_t          strb,
  output logic             busy,
  output logic             done,
  output logic             normMode,
  output logic [CNT_W-1:0] countOut
);

  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  typedef enum logic {IDLE, RUN} state_t;

  state_t           state;
  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] stepCnt;
  logic [CNT_W-1:0] progCnt;
  logic             normQ;
  logic             doneQ;
  logic             finish;

  // End of operation: normalize stops on a set top bit or at the step limit
  always_comb begin
    if (normQ) finish = msb || (stepCnt == LAST_STEP);
    else       finish = (remain == '0);
  end

  always_comb begin
    strb.load     = (state == IDLE) && start;
    strb.step     = (state == RUN) && !finish;
    strb.normStep = normQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= IDLE;
      remain  <= '0;
      stepCnt <= '0;
      progCnt <= '0;
      normQ   <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        IDLE: begin
          if (start) begin
            remain  <= countIn;
            progCnt <= countIn;
            normQ   <= (countIn == '0);
            stepCnt <= '0;
            state   <= RUN;
          end
        end
        RUN: begin
          if (finish) begin
            state <= IDLE;
            doneQ <= 1'b1;
          end else if (normQ) begin
            stepCnt <= stepCnt + 1'b1;
          end else begin
            remain <= remain - 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign busy     = (state == RUN);
  assign done     = doneQ;
  assign normMode = normQ;
  assign countOut = normQ ? stepCnt : progCnt;

endmodule

// File: rtl/shift_norm_dp.sv
module shift_norm_dp
  import shift_norm_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             carryIn,
  input  shiftCfg_t        cfgIn,
  output logic [WIDTH-1:0] wordOut,
  output logic             carryOut,
  output logic             msb
);

  logic [WIDTH-1:0] wordQ;
  logic             carryQ;
  shiftCfg_t        cfgQ;
  shiftCfg_t        effCfg;
  logic [WIDTH-1:0] nextWord;
  logic             nextCarry;
  logic             fillBit;
  logic             leaveBit;

  // Normalize always steps left with zero fill and leaves the carry alone
  always_comb begin
    if (strb.normStep) effCfg = '{right: 1'b0, circ: 1'b0, withCarry: 1'b0};
    else               effCfg = cfgQ;
  end

  always_comb begin
    leaveBit = effCfg.right ? wordQ[0] : wordQ[WIDTH-1];
    if (!effCfg.circ)        fillBit = 1'b0;
    else if (effCfg.withCarry) fillBit = carryQ;
    else                     fillBit = leaveBit;
    if (effCfg.right) nextWord = {fillBit, wordQ[WIDTH-1:1]};
    else              nextWord = {wordQ[WIDTH-2:0], fillBit};
    nextCarry = effCfg.withCarry ? leaveBit : carryQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ  <= '0;
      carryQ <= 1'b0;
      cfgQ   <= '0;
    end else if (strb.load) begin
      wordQ  <= dataIn;
      carryQ <= carryIn;
      cfgQ   <= cfgIn;
    end else if (strb.step) begin
      wordQ  <= nextWord;
      carryQ <= nextCarry;
    end
  end

  assign wordOut  = wordQ;
  assign carryOut = carryQ;
  assign msb      = wordQ[WIDTH-1];

endmodule

// File: rtl/shift_norm_unit.sv
module shift_norm_unit
  import shift_norm_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] dataIn,
  input  logic [CNT_W-1:0] countIn,
  input  logic             shiftRight,
  input  logic             circular,
  input  logic             withCarry,
  input  logic             carryIn,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] dataOut,
  output logic             carryOut,
  output logic [CNT_W-1:0] countOut
);

  strobe_t   strb;
  shiftCfg_t cfgIn;
  logic      msb;
  logic      normMode;

  assign cfgIn = '{right: shiftRight, circ: circular, withCarry: withCarry};

  shift_norm_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .countIn  (countIn),
    .msb      (msb),
    .strb     (strb),
    .busy     (busy),
    .done     (done),
    .normMode (normMode),
    .countOut (countOut)
  );

  shift_norm_dp #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .dataIn   (dataIn),
    .carryIn  (carryIn),
    .cfgIn    (cfgIn),
    .wordOut  (dataOut),
    .carryOut (carryOut),
    .msb      (msb)
  );

endmodule

// File: rtl/shift_norm_chk.sv
module shift_norm_chk #(
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             normMode,
  input logic [WIDTH-1:0] dataOut,
  input logic             carryOut,
  input logic [CNT_W-1:0] countOut
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R8

  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);  // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(dataOut) && $stable(carryOut) && $stable(countOut)));  // R8

  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));  // R9

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(normMode));  // R9

  AST_NORM_TOP_SET: assert property (@(posedge clk) disable iff (!rstN)
    (done && normMode && dataOut != '0) |-> dataOut[WIDTH-1]);  // R6

  AST_NORM_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (done && normMode && dataOut == '0) |-> (countOut == CNT_W'(WIDTH - 1)));  // R7

  AST_SHIFT_COUNT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !normMode) |=> $stable(countOut));  // R11

endmodule

bind shift_norm_unit shift_norm_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .normMode (normMode),
  .dataOut  (dataOut),
  .carryOut (carryOut),
  .countOut (countOut)
);

// File: tb/shift_norm_unit_tb.sv
module shift_norm_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dataIn = '0;
  logic [4:0]  countIn = '0;
  logic        shiftRight = 1'b0;
  logic        circular = 1'b0;
  logic        withCarry = 1'b0;
  logic        carryIn = 1'b0;
  logic        busy, done, carryOut;
  logic [31:0] dataOut;
  logic [4:0]  countOut;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  shift_norm_unit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .dataIn(dataIn), .countIn(countIn),
    .shiftRight(shiftRight), .circular(circular), .withCarry(withCarry),
    .carryIn(carryIn), .busy(busy), .done(done), .dataOut(dataOut),
    .carryOut(carryOut), .countOut(countOut)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Reference result computed behaviourally from the requirements
  task automatic refOp(input logic [31:0] d, input int k, input bit right, input bit circ,
                       input bit wc, input bit cin,
                       output logic [31:0] eD, output bit eC, output int eN, output int steps);
    logic [32:0] ring;
    if (k == 0) begin
      int lz = 0;
      for (int i = 31; i >= 0; i--) begin
        if (d[i]) break;
        lz++;
      end
      if (lz > 31) lz = 31;
      eD = d << lz; eC = cin; eN = lz; steps = lz;
    end else begin
      steps = k; eN = k;
      if (wc && circ) begin
        ring = {cin, d};
        for (int i = 0; i < k; i++)
          ring = right ? {ring[0], ring[32:1]} : {ring[31:0], ring[32]};
        eC = ring[32]; eD = ring[31:0];
      end else if (circ) begin
        eD = right ? ((d >> k) | (d << (32 - k))) : ((d << k) | (d >> (32 - k)));
        eC = cin;
      end else begin
        eD = right ? (d >> k) : (d << k);
        eC = wc ? (right ? d[k-1] : d[32-k]) : cin;
      end
    end
  endtask

  task automatic runOp(input logic [31:0] d, input int k, input bit right, input bit circ,
                       input bit wc, input bit cin, input bit poke, input string tag);
    logic [31:0] eD; bit eC; int eN; int steps;
    refOp(d, k, right, circ, wc, cin, eD, eC, eN, steps);
    @(negedge clk);
    dataIn = d; countIn = 5'(k); shiftRight = right; circular = circ;
    withCarry = wc; carryIn = cin; start = 1'b1;
    @(negedge clk);  // edge 0 has accepted the start
    start = 1'b0;
    for (int j = 0; j <= steps; j++) begin
      chk(busy, 1, {"R8 busy while running (", tag, ")"});
      chk(done, 0, {"R8 done early (", tag, ")"});
      if (k != 0) chk(countOut, k, "R11 count echoed while running");
      if (poke && j == 0) begin
        start = 1'b1; dataIn = ~d; countIn = 5'd3; carryIn = ~cin;
        shiftRight = ~right; circular = ~circ; withCarry = ~wc;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(done, 1, {"R8 done pulse (", tag, ")"});
    chk(busy, 0, {"R8 busy dropped (", tag, ")"});
    chk(dataOut, eD, {tag, " data"});
    chk(carryOut, eC, {tag, " carry"});
    chk(countOut, eN, {tag, " count"});
    @(negedge clk);
    chk(done, 0, "R8 done lasts one cycle");
    chk(dataOut, eD, "R8 data held while idle");
    chk(carryOut, eC, "R8 carry held while idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, carryOut}, 3'b000, "R10 reset flags");
    chk(dataOut, 0, "R10 reset data");
    chk(countOut, 0, "R10 reset count");
    rstN = 1'b1;
    @(negedge clk);
    chk(busy, 0, "R10 idle after reset");

    // left/right logical shifts, carry untouched
    runOp(32'h8000_0001, 1, 0, 0, 0, 1, 0, "R1");
    runOp(32'hF0F0_1234, 4, 0, 0, 0, 0, 0, "R1");
    runOp(32'h8000_0001, 31, 1, 0, 0, 1, 0, "R2");
    runOp(32'hDEAD_BEEF, 8, 1, 0, 0, 0, 0, "R2");
    // 32-bit rotation
    runOp(32'h8000_0001, 1, 0, 1, 0, 0, 0, "R3");
    runOp(32'h1234_5678, 12, 1, 1, 0, 1, 0, "R3");
    // carry in the path, zero fill
    runOp(32'h4000_0000, 2, 0, 0, 1, 0, 0, "R4");
    runOp(32'h0000_0005, 1, 1, 0, 1, 1, 0, "R4");
    runOp(32'h0000_0005, 3, 1, 0, 1, 1, 0, "R4");
    // 33-bit ring through the carry
    runOp(32'h8000_0000, 1, 0, 1, 1, 0, 0, "R5");
    runOp(32'hA5A5_0F0F, 5, 0, 1, 1, 1, 0, "R5");
    runOp(32'h0000_0001, 31, 1, 1, 1, 0, 0, "R5");
    // normalize, with shift controls set to show they are ignored
    runOp(32'h0000_1000, 0, 1, 1, 1, 1, 0, "R6");
    runOp(32'h8000_0000, 0, 1, 0, 1, 0, 0, "R6");
    runOp(32'h0000_0001, 0, 0, 1, 0, 1, 0, "R6");
    runOp(32'h0000_0000, 0, 1, 1, 1, 1, 0, "R7");
    // start while busy
    runOp(32'h0F00_00F0, 6, 0, 1, 1, 0, 1, "R9");
    runOp(32'h0000_0300, 0, 0, 0, 0, 0, 1, "R9");
    runOp(32'h9000_0000, 0, 0, 0, 0, 1, 1, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule